// File: doc/BRIEF.md
# Exclusive Load Execute Unit

This unit executes the word and doubleword load-acquire-exclusive operation of a 64-bit load/store pipeline. The pipeline presents a 32-bit instruction word, the value of the general register named as the base, and the current stack pointer. The unit recognises the exclusive-load encoding and picks the base address. It then makes a single atomic read of 4 or 8 bytes over a valid/ready request port with a valid-only response port. It zero-extends the returned data and writes it back to the destination register. Flags are not part of its interface and are never touched.

When the read is handed to memory, a local exclusive monitor records the address and the access size. A later store-exclusive asks through a check port whether that reservation still holds. Each check consumes the reservation. A clear input, reset, a newer exclusive load, or a misaligned exclusive load also removes it. Acquire ordering is shown to the pipeline as a hold signal that stays high from the cycle after issue until the response arrives.

Top module: `excl_load_unit`

## Requirements
- R1: An instruction is taken only when bit 31 is 1, bits 29:23 are 0010000, bit 22 is 1, bit 21 is 0, bits 20:16 and 14:10 are all ones and bit 15 is 1 (mask 0xBFFFFC00, value 0x885FFC00). `op_hit` shows a match. A presented word that does not match causes no request and no writeback.
- R2: Instruction bit 30 selects the size. 0 gives a 4-byte read (`mreq_size8`=0) and 1 gives an 8-byte read (`mreq_size8`=1) that writes all 64 returned bits.
- R3: The base index in bits 9:5 equal to 31 takes the address from `op_sp`. Any other index takes it from `op_gpr_base`. The address appears unchanged on `mreq_addr`.
- R4: With base index 31 and a stack pointer whose low 4 bits are not all zero, `fault_align` pulses for one cycle after the accepting edge. No request is issued and the unit stays ready.
- R5: A 4-byte load writes zeros to bits 63:32 of `wb_data` and the returned bits 31:0 below them.
- R6: `wb_valid` is high for exactly one cycle, the cycle after the edge where `mrsp_valid` was sampled. `wb_idx` carries instruction bits 4:0.
- R7: `younger_hold` is high from the cycle after acceptance until the response edge. `op_ready` (and `busy` inverted) stays low until the writeback cycle has passed.
- R8: A read to an address aligned to its size arms the monitor when its request handshake completes. A check with the same address and size then gives `sx_ok`=1.
- R9: A read to an address not aligned to its size is still issued, but leaves the monitor cleared, wiping any earlier reservation.
- R10: A check whose address or size differs from the reservation gives `sx_ok`=0. Every check, passing or failing, clears the monitor.
- R11: `clr_mon` and `rst` both clear the monitor.
- R12: A newer exclusive load replaces the reservation of an older one.
- R13: While `mreq_valid` is high and `mreq_ready` is low, the request stays valid with a stable address and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction presented |
| op_ready | output | 1 | Unit idle and able to take an instruction |
| op_insn | input | 32 | Instruction word |
| op_gpr_base | input | 64 | Value of the general register named by bits 9:5 |
| op_sp | input | 64 | Current stack pointer |
| op_hit | output | 1 | Presented word matches the exclusive-load encoding |
| fault_align | output | 1 | One-cycle stack pointer alignment fault |
| busy | output | 1 | Operation in flight, from issue to writeback |
| younger_hold | output | 1 | Younger memory operations must wait (acquire) |
| mreq_valid | output | 1 | Read request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | 64 | Read address |
| mreq_size8 | output | 1 | 1 for an 8-byte read, 0 for 4 bytes |
| mrsp_valid | input | 1 | Read data returned |
| mrsp_data | input | 64 | Returned data |
| wb_valid | output | 1 | Register writeback strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Zero-extended writeback value |
| clr_mon | input | 1 | Clear the exclusive monitor |
| sx_valid | input | 1 | Store-exclusive check request |
| sx_addr | input | 64 | Store-exclusive address |
| sx_size8 | input | 1 | Store-exclusive size, 1 for 8 bytes |
| sx_ok | output | 1 | Reservation holds for this check |

## Verification
The bench targets the encoding boundary with a word one bit off the pattern. A loose decoder would issue a read for it. It drives a stack-pointer base with low bits set, which a unit that skips the alignment test would turn into a request. A 4-byte load returns data with a full upper half, so a missing zero-extension shows in `wb_data`. The monitor is probed with matching, shifted-address and wrong-size checks, a repeated check, an unaligned load that must wipe an earlier reservation, a newer load that must replace it, and `clr_mon` and reset clears. A monitor that forgets to clear after a check, or arms on misaligned addresses, reports success where none is due.

// File: rtl/excl_pkg.sv
package excl_pkg;

    localparam logic [31:0] LDX_MASK  = 32'hBFFF_FC00;
    localparam logic [31:0] LDX_MATCH = 32'h885F_FC00;
    localparam int          WIDE_BIT  = 30;
    localparam logic [4:0]  SP_INDEX  = 5'd31;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_REQ,
        XS_WAIT,
        XS_WB
    } xstate_e;

    typedef struct packed {
        logic       hit;
        logic       wide;
        logic       fault;
        logic [4:0] rd;
    } xop_t;

    function automatic logic is_ldx(input logic [31:0] w);
        return (w & LDX_MASK) == LDX_MATCH;
    endfunction

    function automatic logic size_aligned(input logic [2:0] lo, input logic wide);
        return wide ? (lo == 3'b000) : (lo[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/excl_decode.sv
module excl_decode
    import excl_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int SP_ALIGN_LG = 4
) (
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] gpr_base,
    input  logic [XLEN-1:0] sp_val,
    output xop_t            op,
    output logic [XLEN-1:0] addr
);
    logic [4:0] rn;
    logic       use_sp;

    always_comb begin
        rn       = insn[9:5];
        use_sp   = (rn == SP_INDEX);
        op.hit   = is_ldx(insn);
        op.wide  = insn[WIDE_BIT];
        op.rd    = insn[4:0];
        op.fault = use_sp && (sp_val[SP_ALIGN_LG-1:0] != '0);
        addr     = use_sp ? sp_val : gpr_base;
    end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          arm_en,
    input  logic [AW-1:0] arm_addr,
    input  logic          arm_wide,
    input  logic          chk_en,
    input  logic [AW-1:0] chk_addr,
    input  logic          chk_wide,
    output logic          chk_ok
);
    logic          armed;
    logic [AW-1:0] res_addr;
    logic          res_wide;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed    <= 1'b0;
            res_addr <= '0;
            res_wide <= 1'b0;
        end else if (arm_en) begin
            armed    <= size_aligned(arm_addr[2:0], arm_wide);
            res_addr <= arm_addr;
            res_wide <= arm_wide;
        end else if (chk_en) begin
            armed <= 1'b0;
        end
    end

    assign chk_ok = chk_en && armed && (chk_addr == res_addr) && (chk_wide == res_wide);

endmodule

// File: rtl/excl_load_unit.sv
module excl_load_unit
    import excl_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int SP_ALIGN_LG = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    output logic            op_ready,
    input  logic [31:0]     op_insn,
    input  logic [XLEN-1:0] op_gpr_base,
    input  logic [XLEN-1:0] op_sp,
    output logic            op_hit,
    output logic            fault_align,
    output logic            busy,
    output logic            younger_hold,
    output logic            mreq_valid,
    input  logic            mreq_ready,
    output logic [XLEN-1:0] mreq_addr,
    output logic            mreq_size8,
    input  logic            mrsp_valid,
    input  logic [XLEN-1:0] mrsp_data,
    output logic            wb_valid,
    output logic [4:0]      wb_idx,
    output logic [XLEN-1:0] wb_data,
    input  logic            clr_mon,
    input  logic            sx_valid,
    input  logic [XLEN-1:0] sx_addr,
    input  logic            sx_size8,
    output logic            sx_ok
);
    localparam int HALF = 32;

    xop_t            dec;
    logic [XLEN-1:0] dec_addr;
    xstate_e         state;
    logic [XLEN-1:0] cur_addr;
    logic            cur_wide;
    logic [4:0]      cur_rd;
    logic [XLEN-1:0] data_q;
    logic            fault_q;
    logic            try_take;
    logic            accept;
    logic            arm_fire;

    excl_decode #(.XLEN(XLEN), .SP_ALIGN_LG(SP_ALIGN_LG)) u_dec (
        .insn     (op_insn),
        .gpr_base (op_gpr_base),
        .sp_val   (op_sp),
        .op       (dec),
        .addr     (dec_addr)
    );

    assign try_take = op_valid && op_ready && dec.hit;
    assign accept   = try_take && !dec.fault;
    assign arm_fire = (state == XS_REQ) && mreq_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= XS_IDLE;
            cur_addr <= '0;
            cur_wide <= 1'b0;
            cur_rd   <= '0;
            data_q   <= '0;
            fault_q  <= 1'b0;
        end else begin
            fault_q <= try_take && dec.fault;
            unique case (state)
                XS_IDLE: if (accept) begin
                    state    <= XS_REQ;
                    cur_addr <= dec_addr;
                    cur_wide <= dec.wide;
                    cur_rd   <= dec.rd;
                end
                XS_REQ:  if (mreq_ready) state <= XS_WAIT;
                XS_WAIT: if (mrsp_valid) begin
                    state  <= XS_WB;
                    data_q <= mrsp_data;
                end
                XS_WB:   state <= XS_IDLE;
                default: state <= XS_IDLE;
            endcase
        end
    end

    assign op_ready     = (state == XS_IDLE);
    assign busy         = !op_ready;
    assign op_hit       = op_valid && dec.hit;
    assign fault_align  = fault_q;
    assign younger_hold = (state == XS_REQ) || (state == XS_WAIT);
    assign mreq_valid   = (state == XS_REQ);
    assign mreq_addr    = cur_addr;
    assign mreq_size8   = cur_wide;
    assign wb_valid     = (state == XS_WB);
    assign wb_idx       = cur_rd;
    assign wb_data      = cur_wide ? data_q : {{(XLEN-HALF){1'b0}}, data_q[HALF-1:0]};

    excl_monitor #(.AW(XLEN)) u_mon (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_mon),
        .arm_en   (arm_fire),
        .arm_addr (cur_addr),
        .arm_wide (cur_wide),
        .chk_en   (sx_valid),
        .chk_addr (sx_addr),
        .chk_wide (sx_size8),
        .chk_ok   (sx_ok)
    );

endmodule

// File: rtl/excl_load_unit_chk.sv
module excl_load_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            op_ready,
    input logic            fault_align,
    input logic            younger_hold,
    input logic            mreq_valid,
    input logic            mreq_ready,
    input logic [XLEN-1:0] mreq_addr,
    input logic            mreq_size8,
    input logic            mrsp_valid,
    input logic            wb_valid,
    input logic [XLEN-1:0] wb_data,
    input logic            cur_wide,
    input logic            clr_mon,
    input logic            sx_valid,
    input logic            sx_ok,
    input logic            arm_fire
);
    p_req_stable_r13: assert property (@(posedge clk) disable iff (rst)
        mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_size8));

    p_hold_in_flight_r7: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> younger_hold && !op_ready);

    p_wb_after_rsp_r6: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(younger_hold && mrsp_valid));

    p_wb_single_r6: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !wb_valid);

    p_zero_upper_r5: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !cur_wide |-> wb_data[XLEN-1:32] == '0);

    p_fault_no_req_r4: assert property (@(posedge clk) disable iff (rst)
        fault_align |-> !mreq_valid && op_ready);

    p_check_consumes_r10: assert property (@(posedge clk) disable iff (rst)
        $past(sx_valid) && !$past(arm_fire) |-> !sx_ok);

    p_clear_input_r11: assert property (@(posedge clk) disable iff (rst)
        $past(clr_mon) |-> !sx_ok);

endmodule

bind excl_load_unit excl_load_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_ready     (op_ready),
    .fault_align  (fault_align),
    .younger_hold (younger_hold),
    .mreq_valid   (mreq_valid),
    .mreq_ready   (mreq_ready),
    .mreq_addr    (mreq_addr),
    .mreq_size8   (mreq_size8),
    .mrsp_valid   (mrsp_valid),
    .wb_valid     (wb_valid),
    .wb_data      (wb_data),
    .cur_wide     (cur_wide),
    .clr_mon      (clr_mon),
    .sx_valid     (sx_valid),
    .sx_ok        (sx_ok),
    .arm_fire     (arm_fire)
);

// File: tb/excl_load_unit_bench.sv
module excl_load_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_ready, op_hit, fault_align, busy, younger_hold;
    logic [31:0] op_insn;
    logic [63:0] op_gpr_base, op_sp;
    logic        mreq_valid, mreq_ready, mreq_size8;
    logic [63:0] mreq_addr;
    logic        mrsp_valid;
    logic [63:0] mrsp_data;
    logic        wb_valid;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;
    logic        clr_mon, sx_valid, sx_size8, sx_ok;
    logic [63:0] sx_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    excl_load_unit u_excl_load_unit (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_ready(op_ready), .op_insn(op_insn),
        .op_gpr_base(op_gpr_base), .op_sp(op_sp), .op_hit(op_hit),
        .fault_align(fault_align), .busy(busy), .younger_hold(younger_hold),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
        .mreq_size8(mreq_size8), .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .clr_mon(clr_mon), .sx_valid(sx_valid), .sx_addr(sx_addr),
        .sx_size8(sx_size8), .sx_ok(sx_ok)
    );

    typedef struct packed {
        logic [31:0] insn;
        logic [63:0] gpr;
        logic [63:0] sp;
        logic [63:0] rsp;
        logic        req;
        logic        fault;
        logic        wide;
        logic [63:0] addr;
        logic [63:0] data;
        logic [4:0]  idx;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h885FFC23, 64'h0000_0000_1000_0040, 64'h0, 64'hDEAD_BEEF_1234_5678,
          1'b1, 1'b0, 1'b0, 64'h0000_0000_1000_0040, 64'h0000_0000_1234_5678, 5'd3},
        '{32'hC85FFC47, 64'h0000_0000_2000_0008, 64'h0, 64'hCAFE_F00D_55AA_33CC,
          1'b1, 1'b0, 1'b1, 64'h0000_0000_2000_0008, 64'hCAFE_F00D_55AA_33CC, 5'd7},
        '{32'h885FFFE0, 64'h0000_0000_0000_1234, 64'h7FF0, 64'hFFFF_FFFF_8000_0001,
          1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_7FF0, 64'h0000_0000_8000_0001, 5'd0},
        '{32'hC85FFFE5, 64'h0000_0000_0000_0100, 64'h7FF8, 64'h0,
          1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 5'd5},
        '{32'h887FFC00, 64'h0000_0000_0000_0100, 64'h0, 64'h0,
          1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 5'd0},
        '{32'hC85FFC9F, 64'h0000_0000_0000_0040, 64'h0, 64'h0123_4567_89AB_CDEF,
          1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_0040, 64'h0123_4567_89AB_CDEF, 5'd31}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one instruction through the unit; memory waits one cycle before ready.
    task automatic run_op(input vec_t v, input bit verify);
        @(negedge clk);
        op_valid = 1'b1; op_insn = v.insn; op_gpr_base = v.gpr; op_sp = v.sp;
        #1;
        if (verify) chk(op_hit == (v.req || v.fault), "R1 hit", 64'(op_hit), 64'(v.req || v.fault));
        @(negedge clk);
        op_valid = 1'b0;
        if (verify) begin
            chk(fault_align == v.fault, "R4 fault", 64'(fault_align), 64'(v.fault));
            chk(mreq_valid == v.req, "R1 request issued", 64'(mreq_valid), 64'(v.req));
        end
        if (!v.req) begin
            @(negedge clk);
            if (verify) begin
                chk(!fault_align, "R4 fault one cycle", 64'(fault_align), 64'd0);
                chk(op_ready && !wb_valid && !mreq_valid, "R1 ignored/no writeback",
                    {61'd0, op_ready, wb_valid, mreq_valid}, 64'd4);
            end
            return;
        end
        if (verify) begin
            chk(mreq_addr == v.addr, "R3 address", mreq_addr, v.addr);
            chk(mreq_size8 == v.wide, "R2 size", 64'(mreq_size8), 64'(v.wide));
            chk(younger_hold && busy, "R7 hold at request", {62'd0, younger_hold, busy}, 64'd3);
        end
        @(negedge clk);
        if (verify) chk(mreq_valid && mreq_addr == v.addr, "R13 held while not ready", mreq_addr, v.addr);
        mreq_ready = 1'b1;
        @(negedge clk);
        mreq_ready = 1'b0;
        if (verify) chk(!mreq_valid && younger_hold && !op_ready, "R7 hold while waiting",
                        {61'd0, mreq_valid, younger_hold, op_ready}, 64'd2);
        mrsp_valid = 1'b1; mrsp_data = v.rsp;
        @(negedge clk);
        mrsp_valid = 1'b0; mrsp_data = '0;
        if (verify) begin
            chk(wb_valid, "R6 writeback strobe", 64'(wb_valid), 64'd1);
            chk(wb_idx == v.idx, "R6 destination", 64'(wb_idx), 64'(v.idx));
            chk(wb_data == v.data, v.wide ? "R2 full width" : "R5 zero-extend", wb_data, v.data);
            chk(!younger_hold && !op_ready, "R7 release at writeback", {62'd0, younger_hold, op_ready}, 64'd0);
        end
        @(negedge clk);
        if (verify) chk(!wb_valid && op_ready && !busy, "R6/R7 back to idle",
                        {61'd0, wb_valid, op_ready, busy}, 64'd2);
    endtask

    task automatic load_at(input logic [63:0] a, input bit wide);
        vec_t v;
        v = '{insn: (wide ? 32'hC85FFC00 : 32'h885FFC00) | 32'h22, gpr: a, sp: 64'h0,
              rsp: 64'h55, req: 1'b1, fault: 1'b0, wide: wide, addr: a,
              data: 64'h55, idx: 5'd2};
        run_op(v, 1'b0);
    endtask

    task automatic sx_probe(input logic [63:0] a, input bit wide, input bit exp, input string req);
        @(negedge clk);
        sx_valid = 1'b1; sx_addr = a; sx_size8 = wide;
        #1;
        chk(sx_ok == exp, req, 64'(sx_ok), 64'(exp));
        @(negedge clk);
        sx_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_valid = 0; op_insn = 0; op_gpr_base = 0; op_sp = 0;
        mreq_ready = 0; mrsp_valid = 0; mrsp_data = 0;
        clr_mon = 0; sx_valid = 0; sx_addr = 0; sx_size8 = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(op_ready && !busy && !mreq_valid && !wb_valid && !younger_hold && !fault_align,
            "R7 reset idle", {58'd0, op_ready, busy, mreq_valid, wb_valid, younger_hold, fault_align}, 64'h20);
        sx_probe(64'h0, 1'b0, 1'b0, "R11 reset leaves monitor clear");

        for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b1);

        load_at(64'h100, 1'b0);
        sx_probe(64'h100, 1'b0, 1'b1, "R8 matching check passes");
        sx_probe(64'h100, 1'b0, 1'b0, "R10 cleared after check");

        load_at(64'h100, 1'b0);
        sx_probe(64'h104, 1'b0, 1'b0, "R10 address mismatch");
        sx_probe(64'h100, 1'b0, 1'b0, "R10 failed check clears");

        load_at(64'h100, 1'b0);
        sx_probe(64'h100, 1'b1, 1'b0, "R10 size mismatch");

        load_at(64'h108, 1'b1);
        sx_probe(64'h108, 1'b1, 1'b1, "R8 doubleword reservation");

        load_at(64'h100, 1'b0);
        load_at(64'h104, 1'b1);
        sx_probe(64'h104, 1'b1, 1'b0, "R9 unaligned not armed");
        load_at(64'h100, 1'b0);
        load_at(64'h104, 1'b1);
        sx_probe(64'h100, 1'b0, 1'b0, "R9 unaligned wipes earlier");

        load_at(64'h100, 1'b0);
        load_at(64'h200, 1'b1);
        sx_probe(64'h200, 1'b1, 1'b1, "R12 newer reservation holds");
        load_at(64'h100, 1'b0);
        load_at(64'h200, 1'b1);
        sx_probe(64'h100, 1'b0, 1'b0, "R12 older reservation gone");

        load_at(64'h300, 1'b0);
        @(negedge clk); clr_mon = 1'b1;
        @(negedge clk); clr_mon = 1'b0;
        sx_probe(64'h300, 1'b0, 1'b0, "R11 clear input");

        load_at(64'h300, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        sx_probe(64'h300, 1'b0, 1'b0, "R11 reset clears monitor");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule